// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers up to `NUM_SRC` hardware event pulses into a pending cause register. Software reads, acknowledges and masks those causes through a small word-indexed register bus. Every source keeps the same bit position in every register.

Each bit has its own acknowledge style, chosen at run time:
- write-one-to-clear, or
- clear-on-read.

A masked view returns only the causes that are not suppressed. The mask can be changed in three ways:
- a full write,
- an atomic set port,
- an atomic clear port.

Software can also raise a cause itself through a write-only set port. One registered interrupt line is high whenever any unmasked cause is pending.

Read data is registered. A read presents `regSel` with `rdEn` for one cycle, and the value appears on `rdData` after that clock edge. The value then holds until the next accepted read.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset, cause and clear-mode are all zeros, mask is all ones, `irqOut` is 0 and `rdData` is 0.
- R2: Register index map, which sets the bus address each register answers to: 0 = clear-mode, 1 = cause, 2 = masked cause, 3 = cause-set, 4 = mask, 5 = mask-set, 6 = mask-clear. A read value appears on `rdData` the cycle after `rdEn`. Reads of indices 3, 5, 6 and 7 return zero.
- R3: A 1 on `hwEvent[i]` sets cause bit i at that clock edge. A set and a clear on the same bit in the same cycle leave the bit set.
- R4: A bit with clear-mode 0 clears when a 1 is written to it at index 1 or index 2. Zero bits in the write leave it alone, and reading it does not clear it.
- R5: A bit with clear-mode 1 clears when index 1 is read and the read returns it. Writing 1 to it at index 1 or 2 has no effect.
- R6: Index 2 reads as cause AND NOT mask. A read of index 2 clears only the clear-on-read bits it returned, so masked pending bits survive.
- R7: Writing 1s to index 3 sets those cause bits, and 0s leave the others unchanged.
- R8: Index 4 reads and writes the mask directly. 1s written to index 5 set mask bits, and 1s written to index 6 clear them. Zero bits at either port leave the mask unchanged.
- R9: `irqOut` is a register. One cycle after the state changes, it equals the OR over all bits of cause AND NOT mask, so it is 0 whenever all mask bits are 1.
- R10: When `wrEn` and `rdEn` are both high, only the write is performed. The read has no effect and `rdData` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwEvent | input | NUM_SRC | Per-source event pulses |
| regSel | input | 3 | Register word index |
| wrEn | input | 1 | Write strobe |
| wrData | input | NUM_SRC | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | NUM_SRC | Registered read data |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Every register effect of an access lands on the clock edge that samples the access. The bench therefore drives each access on a falling edge and reads back `rdData` at the next falling edge, one edge later. Cause and mask changes are checked by a following read.

`irqOut` lags the state by one register stage. The bench compares it only after one idle cycle, once the state has settled, against the OR of its own model of cause AND NOT mask. Same-cycle races between an event and a clear are driven in the same cycle as the access, so the set-wins rule is checked at the edge where both act.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_MODE     = 3'd0,
    IDX_CAUSE    = 3'd1,
    IDX_MASKED   = 3'd2,
    IDX_CAUSESET = 3'd3,
    IDX_MASK     = 3'd4,
    IDX_MASKSET  = 3'd5,
    IDX_MASKCLR  = 3'd6,
    IDX_SPARE    = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic wrMode;
    logic wrCause;
    logic wrMasked;
    logic wrCauseSet;
    logic wrMask;
    logic wrMaskSet;
    logic wrMaskClr;
    logic rdAny;
    logic rdCause;
    logic rdMasked;
  } bankStrobes_t;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  output bankStrobes_t     strb
);
  logic rdOk;

  // A write takes precedence over a read issued in the same cycle.
  assign rdOk = rdEn && !wrEn;

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (regIdx_e'(regSel))
        IDX_MODE:     strb.wrMode     = 1'b1;
        IDX_CAUSE:    strb.wrCause    = 1'b1;
        IDX_MASKED:   strb.wrMasked   = 1'b1;
        IDX_CAUSESET: strb.wrCauseSet = 1'b1;
        IDX_MASK:     strb.wrMask     = 1'b1;
        IDX_MASKSET:  strb.wrMaskSet  = 1'b1;
        IDX_MASKCLR:  strb.wrMaskClr  = 1'b1;
        default:      ;
      endcase
    end
    strb.rdAny    = rdOk;
    strb.rdCause  = rdOk && (regSel == IDX_CAUSE);
    strb.rdMasked = rdOk && (regSel == IDX_MASKED);
  end

  // R10: a write and a read in the same cycle never both produce strobes.
  p_single_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMode, strb.wrCause, strb.wrMasked, strb.wrCauseSet,
              strb.wrMask, strb.wrMaskSet, strb.wrMaskClr, strb.rdAny}));

  // R10: a write suppresses any read strobe.
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !(strb.rdAny || strb.rdCause || strb.rdMasked));
endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobes_t       strb,
  input  logic [IDX_W-1:0]   regSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] hwEvent,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  localparam logic [NUM_SRC-1:0] ALL_ONES = {NUM_SRC{1'b1}};

  logic [NUM_SRC-1:0] causeQ, modeQ, maskQ, rdQ;
  logic [NUM_SRC-1:0] causeD, maskD, clrVec, setVec, visVec, rdVal;
  logic               irqQ;

  assign visVec = causeQ & ~maskQ;

  always_comb begin
    clrVec = '0;
    if (strb.wrCause || strb.wrMasked) clrVec = clrVec | (wrData & ~modeQ);
    if (strb.rdCause)                  clrVec = clrVec | (causeQ & modeQ);
    if (strb.rdMasked)                 clrVec = clrVec | (visVec & modeQ);
    setVec = hwEvent | (strb.wrCauseSet ? wrData : '0);
    causeD = (causeQ & ~clrVec) | setVec;   // set wins over clear
  end

  always_comb begin
    maskD = maskQ;
    if (strb.wrMask)         maskD = wrData;
    else if (strb.wrMaskSet) maskD = maskQ | wrData;
    else if (strb.wrMaskClr) maskD = maskQ & ~wrData;
  end

  always_comb begin
    unique case (regIdx_e'(regSel))
      IDX_MODE:   rdVal = modeQ;
      IDX_CAUSE:  rdVal = causeQ;
      IDX_MASKED: rdVal = visVec;
      IDX_MASK:   rdVal = maskQ;
      default:    rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      modeQ  <= '0;
      maskQ  <= ALL_ONES;
      rdQ    <= '0;
      irqQ   <= 1'b0;
    end else begin
      causeQ <= causeD;
      maskQ  <= maskD;
      if (strb.wrMode) modeQ <= wrData;
      if (strb.rdAny)  rdQ   <= rdVal;
      irqQ <= |visVec;
    end
  end

  assign rdData = rdQ;
  assign irqOut = irqQ;

  // R3: every event pulse is pending after its edge.
  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|hwEvent) |=> ((causeQ & $past(hwEvent)) == $past(hwEvent)));

  // R4: a write of ones to the cause register clears write-one-to-clear bits.
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCause |=> ((causeQ & $past(wrData & ~modeQ & ~hwEvent)) == '0));

  // R4: a read of the cause register keeps write-one-to-clear bits.
  p_read_keeps_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCause |=> ((causeQ & $past(causeQ & ~modeQ)) == $past(causeQ & ~modeQ)));

  // R5: a read of the cause register clears the clear-on-read bits it returned.
  p_cor_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCause |=> ((causeQ & $past(causeQ & modeQ & ~hwEvent)) == '0));

  // R6: a read of the masked view leaves masked pending bits in place.
  p_masked_read_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdMasked |=> ((causeQ & $past(causeQ & maskQ)) == $past(causeQ & maskQ)));

  // R8: the mask-set port sets the written bits.
  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskSet |=> ((maskQ & $past(wrData)) == $past(wrData)));

  // R8: the mask-clear port clears the written bits.
  p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskClr |=> ((maskQ & $past(wrData)) == '0));

  // R9: a fully masked bank drives no request.
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == ALL_ONES) |=> !irqOut);
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwEvent,
  input  logic [2:0]         regSel,
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               rdEn,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  bankStrobes_t strb;

  irq_bank_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strb   (strb)
  );

  irq_bank_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regSel  (regSel),
    .wrData  (wrData),
    .hwEvent (hwEvent),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/tb_irq_cause_bank.sv
module tb_irq_cause_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] hwEvent = '0;
  logic [2:0]   regSel = '0;
  logic         wrEn = 1'b0;
  logic [N-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic [N-1:0] rdData;
  logic         irqOut;

  int checks = 0;
  int failures = 0;

  // Bench model of the architectural state.
  logic [N-1:0] mCause = '0;
  logic [N-1:0] mMode = '0;
  logic [N-1:0] mMask = '1;
  logic [N-1:0] mRd = '0;

  irq_cause_bank #(.NUM_SRC(N)) dut (
    .clk(clk), .rstN(rstN), .hwEvent(hwEvent), .regSel(regSel),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle, optionally with simultaneous event pulses.
  task automatic busOp(input bit w, input bit r, input int idx,
                       input logic [N-1:0] d, input logic [N-1:0] ev, input string tag);
    logic [N-1:0] clr, setv, expRd;
    clr = '0;
    setv = ev;
    expRd = mRd;
    if (w) begin
      case (idx)
        0: mMode = d;
        1, 2: clr = d & ~mMode;
        3: setv = setv | d;
        4: mMask = d;
        5: mMask = mMask | d;
        6: mMask = mMask & ~d;
        default: ;
      endcase
    end else if (r) begin
      case (idx)
        0: expRd = mMode;
        1: begin expRd = mCause; clr = mCause & mMode; end
        2: begin expRd = mCause & ~mMask; clr = mCause & ~mMask & mMode; end
        4: expRd = mMask;
        default: expRd = '0;
      endcase
    end
    @(negedge clk);
    wrEn = w; rdEn = r; regSel = idx[2:0]; wrData = d; hwEvent = ev;
    @(negedge clk);
    wrEn = 0; rdEn = 0; hwEvent = '0;
    mCause = (mCause & ~clr) | setv;
    mRd = expRd;
    if (r) check(tag, rdData, expRd);
  endtask

  task automatic wr(input int idx, input logic [N-1:0] d, input string tag);
    busOp(1, 0, idx, d, '0, tag);
  endtask

  task automatic rdChk(input int idx, input string tag);
    busOp(0, 1, idx, '0, '0, tag);
  endtask

  task automatic irqChk(input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== (|(mCause & ~mMask))) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irqOut, |(mCause & ~mMask));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 rdData", rdData, '0);
    check("R1 irq", {7'd0, irqOut}, '0);
    rdChk(0, "R1 mode");
    rdChk(1, "R1 cause");
    rdChk(4, "R1 mask");

    // R2 write-only and spare indices read zero
    for (int i = 3; i < 8; i++) if (i != 4) rdChk(i, "R2 zero read");

    // Near-exhaustive sweep over cause patterns and modes
    for (int v = 0; v < 256; v++) begin
      logic [N-1:0] pat, md;
      pat = v[N-1:0];
      md = pat ^ 8'h5a;
      wr(0, md, "R2 mode");
      wr(3, pat, "R7 cause set");
      rdChk(0, "R2 mode readback");
      wr(4, pat ^ 8'hc3, "R8 mask write");
      rdChk(4, "R8 mask readback");
      irqChk("R9 irq");
      rdChk(2, "R6 masked read");
      rdChk(1, "R5 cause read");
      rdChk(1, "R5 cause reread");
      wr(1, 8'hff, "R4 w1c clear");
      rdChk(1, "R4 after w1c");
      wr(5, pat, "R8 mask set");
      rdChk(4, "R8 after set");
      wr(6, ~pat, "R8 mask clear");
      rdChk(4, "R8 after clear");
      wr(3, 8'h0f, "R7 reset cause");
      irqChk("R9 irq after clear");
      wr(2, pat, "R4 masked w1c");
      rdChk(1, "R4 after masked w1c");
      wr(0, 8'h00, "R4 all w1c");
      wr(1, 8'hff, "R4 flush");
    end

    // R3 events, including set-versus-clear races
    wr(0, 8'h00, "R3 w1c mode");
    busOp(0, 0, 0, '0, 8'h81, "R3 event");
    rdChk(1, "R3 event pending");
    busOp(1, 0, 1, 8'hff, 8'h01, "R3 w1c race");
    rdChk(1, "R3 set wins w1c");
    wr(0, 8'hff, "R3 cor mode");
    busOp(0, 1, 1, '0, 8'h01, "R3 cor race read");
    rdChk(1, "R3 set wins cor");

    // R10 write and read together
    wr(4, 8'h00, "R10 unmask");
    rdChk(4, "R10 baseline read");
    busOp(1, 1, 4, 8'h3c, '0, "R10 combined");
    check("R10 rdData holds", rdData, 8'h00);
    rdChk(4, "R10 write took effect");

    // R5 writes ignored by clear-on-read bits
    wr(3, 8'hf0, "R5 set");
    wr(1, 8'hf0, "R5 write ignored");
    rdChk(1, "R5 still pending");
    rdChk(1, "R5 cleared");
    irqChk("R9 final irq");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule